// File: doc/BRIEF.md
# Two-Step Wide Multiply-Accumulate Unit

This unit is a sequenced arithmetic datapath for large-number work such as modular exponentiation and elliptic-curve field arithmetic. Four 32-bit operand words are loaded into local registers. Two 32x32 multipliers then build a 128-bit product over two fixed compute steps. The first step uses the low word of the left operand and the second step uses its high word. Each step adds its two partial products into four 32-bit accumulator words, with the carries passed up from word to word. In accumulate mode the same schedule adds onto the previous result, so software can chain column sums without moving the result through memory.

The same unit also handles 64-bit add, subtract and XOR, and 32-bit shifts, all finished in the first step. Software loads the operands, pulses start with a mode code, and reads the 128-bit result and the carry flag when the one-cycle done pulse arrives. The left 64-bit operand is {C,D} and the right operand is {A,B}. D and B are the low words.

Top module: `mac64_dp`

## Requirements
- R1: While reset is held and after it is released, `res_o` is zero and `carry_o`, `done_o` and `busy_o` are low.
- R2: Mode code 0 (multiply) gives `res_o` = {C,D} * {A,B} as a 128-bit value with `carry_o` low.
- R3: Mode code 1 (multiply-accumulate) gives `res_o` = previous `res_o` + {C,D} * {A,B} modulo 2^128, with `carry_o` set when that sum exceeds 128 bits.
- R4: A carry out of the sum of the two 32-bit partial-product halves that fall into the same word is passed into the next word, so the full-width product is exact.
- R5: Mode code 2 (add) gives {C,D} + {A,B} in bits 63:0 of `res_o` and zeros in bits 127:64, with `carry_o` holding the carry out of bit 63.
- R6: Mode code 3 (subtract) gives {C,D} - {A,B} modulo 2^64 in bits 63:0 of `res_o` and zeros above, with `carry_o` high when {C,D} < {A,B} (borrow).
- R7: Mode code 4 (XOR) gives {C,D} ^ {A,B} in bits 63:0 of `res_o` and zeros above, with `carry_o` low.
- R8: Mode code 5 gives {32'b0,D} << A[4:0] in bits 63:0. Mode code 6 gives D >> A[4:0] in bits 31:0. In both modes the remaining bits of `res_o` and `carry_o` are zero.
- R9: The clock edge that samples `start_i` high while idle starts the operation. `busy_o` is high for the next three cycles. `done_o` is high for exactly one cycle, starting at the third edge after the start edge, and `res_o` and `carry_o` update at that same edge.
- R10: While `busy_o` is high, `start_i` and `load_i` are ignored. No extra operation runs, and the operand registers keep their values.
- R11: `res_o` and `carry_o` change only at the edge that raises `done_o`. Loading new operands while idle leaves them unchanged.
- R12: Mode code 7 repeats the previous `res_o` unchanged, clears `carry_o`, and still produces a done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the four operand words (ignored while busy) |
| op_a_i | input | 32 | Operand word A (high word of the right operand) |
| op_b_i | input | 32 | Operand word B (low word of the right operand) |
| op_c_i | input | 32 | Operand word C (high word of the left operand) |
| op_d_i | input | 32 | Operand word D (low word of the left operand) |
| start_i | input | 1 | Start pulse, sampled while idle |
| mode_i | input | 3 | Operation code, sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 128 | Result words 3..0 |
| carry_o | output | 1 | Carry or borrow flag of the last operation |

## Verification
The assertions assume that `rst_ni` releases between clock edges. They also assume that the mode code sampled at start is the only mode information the unit uses until done. The assertion on operand stability further relies on the rule that `load_i` is ignored while busy. The bench drives every input at the falling edge and holds `start_i` for a single cycle, except in the deliberate overlap test. That test raises start and load again during an operation to show that they are ignored. Expected values come from plain wide arithmetic on the 64-bit operands, which is independent of the word-by-word carry schedule in the design.

// File: rtl/mac64_pkg.sv
package mac64_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_MAC  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_XOR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_HOLD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_STEP1 = 2'd1,
    PH_STEP2 = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  localparam int NUM_WORDS = 4;
endpackage

// File: rtl/mac64_fold.sv
// One compute step: two partial products folded into the accumulator words.
module mac64_fold #(
  parameter int W = 32
) (
  input  logic [W-1:0]                         x_i,
  input  logic [W-1:0]                         b_i,
  input  logic [W-1:0]                         a_i,
  input  logic                                 hi_i,
  input  logic [mac64_pkg::NUM_WORDS*W-1:0]    acc_i,
  output logic [mac64_pkg::NUM_WORDS*W-1:0]    acc_o,
  output logic                                 carry_o
);
  localparam int NW = mac64_pkg::NUM_WORDS;
  localparam int PW = 2 * W;

  logic [PW-1:0] p_b, p_a;
  logic [W+1:0]  term, sum, cy;

  assign p_b = {{W{1'b0}}, x_i} * {{W{1'b0}}, b_i};
  assign p_a = {{W{1'b0}}, x_i} * {{W{1'b0}}, a_i};

  always_comb begin
    cy    = '0;
    acc_o = '0;
    for (int k = 0; k < NW; k++) begin
      int rel;
      rel  = k - (hi_i ? 1 : 0);
      term = '0;
      if (rel == 0)      term = {2'b00, p_b[W-1:0]};
      else if (rel == 1) term = {2'b00, p_b[PW-1:W]} + {2'b00, p_a[W-1:0]};
      else if (rel == 2) term = {2'b00, p_a[PW-1:W]};
      sum = {2'b00, acc_i[k*W +: W]} + term + cy;
      acc_o[k*W +: W] = sum[W-1:0];
      cy = {{W{1'b0}}, sum[W+1:W]};
    end
    carry_o = |cy;
  end
endmodule

// File: rtl/mac64_alu.sv
// Single-step modes: add, subtract, XOR, shifts, hold.
module mac64_alu #(
  parameter int W = 32
) (
  input  mac64_pkg::op_e                       mode_i,
  input  logic [W-1:0]                         a_i,
  input  logic [W-1:0]                         b_i,
  input  logic [W-1:0]                         c_i,
  input  logic [W-1:0]                         d_i,
  input  logic [mac64_pkg::NUM_WORDS*W-1:0]    hold_i,
  output logic [mac64_pkg::NUM_WORDS*W-1:0]    res_o,
  output logic                                 carry_o
);
  import mac64_pkg::*;
  localparam int RW = NUM_WORDS * W;
  localparam int SW = $clog2(W);

  logic [2*W-1:0] lhs, rhs;
  logic [2*W:0]   s;
  logic [SW-1:0]  sh;

  assign lhs = {c_i, d_i};
  assign rhs = {a_i, b_i};
  assign sh  = a_i[SW-1:0];

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    s       = '0;
    unique case (mode_i)
      OP_ADD: begin
        s       = {1'b0, lhs} + {1'b0, rhs};
        res_o   = {{(RW-2*W){1'b0}}, s[2*W-1:0]};
        carry_o = s[2*W];
      end
      OP_SUB: begin
        s       = {1'b0, lhs} - {1'b0, rhs};
        res_o   = {{(RW-2*W){1'b0}}, s[2*W-1:0]};
        carry_o = s[2*W];
      end
      OP_XOR: res_o = {{(RW-2*W){1'b0}}, lhs ^ rhs};
      OP_SHL: res_o = {{(RW-2*W){1'b0}}, {{W{1'b0}}, d_i} << sh};
      OP_SHR: res_o = {{(RW-W){1'b0}}, d_i >> sh};
      default: res_o = hold_i;
    endcase
  end
endmodule

// File: rtl/mac64_ctrl.sv
module mac64_ctrl (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  mac64_pkg::op_e      mode_i,
  output mac64_pkg::phase_e   phase_o,
  output mac64_pkg::op_e      mode_o,
  output logic                busy_o,
  output logic                done_o
);
  import mac64_pkg::*;

  phase_e phase_q;
  op_e    mode_q;
  logic   done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      mode_q  <= OP_MUL;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase_q == PH_WRITE);
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_STEP1;
          mode_q  <= mode_i;
        end
        PH_STEP1: phase_q <= PH_STEP2;
        PH_STEP2: phase_q <= PH_WRITE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign mode_o  = mode_q;
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_step_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STEP1) |=> (phase_q == PH_STEP2));
  assert_done_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WRITE) |=> (done_q && phase_q == PH_IDLE));
  assert_mode_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && phase_q != PH_WRITE) |=> $stable(mode_q));
endmodule

// File: rtl/mac64_dp.sv
module mac64_dp #(
  parameter int W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [W-1:0]         op_a_i,
  input  logic [W-1:0]         op_b_i,
  input  logic [W-1:0]         op_c_i,
  input  logic [W-1:0]         op_d_i,
  input  logic                 start_i,
  input  logic [2:0]           mode_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [4*W-1:0]       res_o,
  output logic                 carry_o
);
  import mac64_pkg::*;
  localparam int RW = NUM_WORDS * W;

  phase_e        phase;
  op_e           mode_q;
  logic [W-1:0]  a_q, b_q, c_q, d_q;
  logic [RW-1:0] acc_q, fold_in, fold_out, alu_res;
  logic          acc_c_q, fold_c, alu_c, mul_type;

  mac64_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (op_e'(mode_i)),
    .phase_o (phase),
    .mode_o  (mode_q),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign mul_type = (mode_q == OP_MUL) || (mode_q == OP_MAC);
  // Plain multiply starts from a cleared accumulator
  assign fold_in  = (phase == PH_STEP1 && mode_q == OP_MUL) ? '0 : acc_q;

  mac64_fold #(.W(W)) i_fold (
    .x_i     ((phase == PH_STEP2) ? c_q : d_q),
    .b_i     (b_q),
    .a_i     (a_q),
    .hi_i    (phase == PH_STEP2),
    .acc_i   (fold_in),
    .acc_o   (fold_out),
    .carry_o (fold_c)
  );

  mac64_alu #(.W(W)) i_alu (
    .mode_i  (mode_q),
    .a_i     (a_q),
    .b_i     (b_q),
    .c_i     (c_q),
    .d_i     (d_q),
    .hold_i  (acc_q),
    .res_o   (alu_res),
    .carry_o (alu_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; c_q <= '0; d_q <= '0;
    end else if (load_i && !busy_o) begin
      a_q <= op_a_i; b_q <= op_b_i; c_q <= op_c_i; d_q <= op_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      acc_c_q <= 1'b0;
      res_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      unique case (phase)
        PH_STEP1: begin
          acc_q   <= mul_type ? fold_out : alu_res;
          acc_c_q <= mul_type ? fold_c : alu_c;
        end
        PH_STEP2: if (mul_type) begin
          acc_q   <= fold_out;
          acc_c_q <= acc_c_q | fold_c;
        end
        PH_WRITE: begin
          res_o   <= acc_q;
          carry_o <= acc_c_q;
        end
        default: ;
      endcase
    end
  end

  assert_ops_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(d_q)));
  assert_res_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(res_o) && $stable(carry_o)));
  assert_mul_no_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == OP_MUL) |-> !carry_o);
  assert_shift_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mode_q == OP_SHL || mode_q == OP_SHR)) |-> (res_o[RW-1:2*W] == '0 && !carry_o));
endmodule

// File: tb/test_mac64_dp.sv
module test_mac64_dp;
  localparam int W = 32;
  localparam int NV = 14;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           load_i = 1'b0, start_i = 1'b0;
  logic [W-1:0]   op_a_i = '0, op_b_i = '0, op_c_i = '0, op_d_i = '0;
  logic [2:0]     mode_i = '0;
  logic           busy_o, done_o, carry_o;
  logic [4*W-1:0] res_o;

  always #5 clk_i = ~clk_i;

  mac64_dp #(.W(W)) i_mac64_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i), .op_d_i(op_d_i),
    .start_i(start_i), .mode_i(mode_i),
    .busy_o(busy_o), .done_o(done_o), .res_o(res_o), .carry_o(carry_o)
  );

  // {mode, A, B, C, D}
  localparam logic [130:0] VEC [NV] = '{
    {3'd0, 32'h0000_0000, 32'h0000_0003, 32'h0000_0000, 32'h0000_0005},
    {3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {3'd0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0FED_CBA9, 32'h8765_4321},
    {3'd1, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0002},
    {3'd2, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {3'd2, 32'h0000_0001, 32'hF000_0000, 32'h0000_0002, 32'h2000_0000},
    {3'd3, 32'h0000_0000, 32'h0000_0007, 32'h0000_0000, 32'h0000_0005},
    {3'd3, 32'h0000_0001, 32'h0000_0001, 32'h0000_0002, 32'h0000_0000},
    {3'd4, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h5A5A_5A5A, 32'hFF00_FF00},
    {3'd5, 32'h0000_001F, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {3'd6, 32'h0000_0004, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000},
    {3'd7, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444},
    {3'd1, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001}
  };

  int n_run = 0, n_fail = 0;
  logic [127:0] prior = '0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [128:0] act, input logic [128:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [128:0] model(input logic [2:0] m, input logic [31:0] a, b, c, d,
                                         input logic [127:0] p);
    logic [128:0] prod, r;
    logic [64:0]  s;
    prod = {65'b0, c, d} * {65'b0, a, b};
    case (m)
      3'd0: r = {1'b0, prod[127:0]};
      3'd1: r = {1'b0, p} + prod;
      3'd2: begin s = {1'b0, c, d} + {1'b0, a, b}; r = {s[64], 64'b0, s[63:0]}; end
      3'd3: begin s = {1'b0, c, d} - {1'b0, a, b}; r = {({c, d} < {a, b}), 64'b0, s[63:0]}; end
      3'd4: r = {65'b0, {c, d} ^ {a, b}};
      3'd5: r = {65'b0, {32'b0, d} << a[4:0]};
      3'd6: r = {97'b0, d >> a[4:0]};
      default: r = {1'b0, p};
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5, 3'd6: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input string tag, input logic [2:0] m, input logic [31:0] a, b, c, d);
    logic [4:0] dn, bz;
    logic [128:0] exp;
    @(negedge clk_i);
    load_i = 1'b1; op_a_i = a; op_b_i = b; op_c_i = c; op_d_i = d;
    @(negedge clk_i);
    load_i = 1'b0; start_i = 1'b1; mode_i = m;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      dn[4-i] = done_o; bz[4-i] = busy_o;
      if (i == 3) begin
        exp = model(m, a, b, c, d, prior);
        check(tag, {carry_o, res_o}, exp);
        prior = exp[127:0];
      end
    end
    // R9: busy for three cycles, done pulse on the third edge
    check("R9", {119'b0, dn, bz}, {119'b0, 5'b00010, 5'b11100});
  endtask

  initial begin : main
    logic [127:0] held;
    repeat (3) @(negedge clk_i);
    check("R1", {busy_o, done_o, carry_o, res_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {busy_o, done_o, carry_o, res_o}, '0);

    for (int v = 0; v < NV; v++)
      run_op(tag_of(VEC[v][130:128]), VEC[v][130:128], VEC[v][127:96], VEC[v][95:64],
             VEC[v][63:32], VEC[v][31:0]);

    // R4: DB high half plus DA low half carries out of 32 bits
    run_op("R4", 3'd0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);

    // R10: second start and load while busy are ignored
    @(negedge clk_i);
    load_i = 1'b1; op_a_i = 32'h0; op_b_i = 32'h9; op_c_i = 32'h0; op_d_i = 32'h7;
    @(negedge clk_i);
    load_i = 1'b0; start_i = 1'b1; mode_i = 3'd0;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 3'd2; load_i = 1'b1; op_b_i = 32'h100; op_d_i = 32'h200;
    @(negedge clk_i);
    start_i = 1'b0; load_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R10", {carry_o, res_o}, {1'b0, 128'd63});
    held = res_o;
    begin
      logic extra;
      extra = 1'b0;
      repeat (6) begin @(negedge clk_i); extra |= done_o | busy_o; end
      check("R10", {128'b0, extra}, '0);
    end
    check("R11", {carry_o, res_o}, {1'b0, held});

    // R11: loading while idle leaves the result alone
    @(negedge clk_i);
    load_i = 1'b1; op_a_i = '1; op_b_i = '1; op_c_i = '1; op_d_i = '1;
    @(negedge clk_i);
    load_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R11", {carry_o, res_o}, {1'b0, held});

    // R12 after R11: hold returns the same value again
    prior = held;
    run_op("R12", 3'd7, '1, '1, '1, '1);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule